// File: doc/BRIEF.md
# Address-Decoded SDRAM Command Port

This block is a bus slave that sits in front of a DDR SDRAM while the memory is being brought up. In command mode, every bus write into the block's address window becomes one raw SDRAM command. The block builds that command entirely from the bus address: one field gives the row/address lines, another the bank lines, and a third the RAS, CAS and WE levels. The write carries no data port, so nothing on the data side reaches the memory.

Firmware brings up the memory by issuing a short run of writes: precharge-all, mode-register loads and auto-refresh, each spaced as the memory needs. It then issues one read from the window. That read ends command mode and raises a sticky enable flag, which hands the memory over to the normal access logic. All outputs are registered, so each bus cycle has a fixed one-cycle latency to the pins.

Top module: `sdcmd_port`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `sd_cke` is 0, `sd_cs_n` is 1, `sd_ras_n`/`sd_cas_n`/`sd_we_n` are 1/1/1, `sd_a` and `sd_ba` are 0, and `ddr_en` is 0.
- R2: A bus write that hits the window while `ddr_en` is 0 produces, in the next cycle only, one command cycle with `sd_cs_n` = 0. In every other cycle `sd_cs_n` = 1, RAS/CAS/WE = 111, and `sd_a` and `sd_ba` are 0.
- R3: In a command cycle, `sd_ras_n`, `sd_cas_n` and `sd_we_n` equal address bits CMD_LSB+2, CMD_LSB+1 and CMD_LSB of the write (default bits 6, 5, 4). The active-low codes pass through unchanged: 111 no-op, 010 precharge, 001 auto refresh, 000 load mode register.
- R4: In a command cycle, `sd_a` equals address bits [BANK_LSB+2+ROW_W-1 : BANK_LSB+2] (default 25:13).
- R5: In a command cycle, `sd_ba` equals address bits [BANK_LSB+1 : BANK_LSB] (default 12:11).
- R6: `sd_cke` goes to 1 in the same cycle as the first command cycle and stays 1 until reset. Reads do not change it.
- R7: A bus read that hits the window sets `ddr_en` in the next cycle. `ddr_en` then stays 1 until reset.
- R8: Once `ddr_en` is 1, bus writes into the window produce no command cycle.
- R9: The window is the set of addresses whose bits [ADDR_W-1:WIN_LSB] equal WIN_TAG (default bits 31:28 = 1). Reads and writes outside the window have no effect on any output.
- R10: A write and a read into the window in the same cycle, while `ddr_en` is 0, produce both the command cycle and the rising `ddr_en` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Bus byte address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | Row address strobe, active low |
| sd_cas_n | output | 1 | Column address strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_a | output | ROW_W | SDRAM address lines |
| sd_ba | output | BANK_W | SDRAM bank address |
| ddr_en | output | 1 | Normal-access enable flag |

## Verification
The bench drives one stimulus stream into two instances. The first uses the default layout: 13 address lines with the bank field at bit 11. The second uses the smaller-density layout: 12 lines with the bank field at bit 10. Because the same bus address is decoded at two different field offsets, any fixed or misplaced bit slice shows up on one of the two instances. Row values that set the top row bit and bank value 3 exercise the edges of each field.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  typedef logic [2:0] sd_cmd_t;

  // active-low RAS, CAS, WE
  localparam sd_cmd_t CMD_NOP = 3'b111;
  localparam sd_cmd_t CMD_PRE = 3'b010;
  localparam sd_cmd_t CMD_REF = 3'b001;
  localparam sd_cmd_t CMD_LMR = 3'b000;
endpackage

// File: rtl/sdcmd_field_decode.sv
module sdcmd_field_decode
  import sdcmd_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int ROW_W    = 13,
  parameter int BANK_W   = 2,
  parameter int BANK_LSB = 11,
  parameter int CMD_LSB  = 4,
  parameter int WIN_LSB  = 28,
  parameter int WIN_TAG  = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [ROW_W-1:0]  row,
  output logic [BANK_W-1:0] bank,
  output sd_cmd_t           cmd
);
  localparam int ROW_LSB = BANK_LSB + BANK_W;
  localparam int WIN_W   = ADDR_W - WIN_LSB;
  localparam logic [WIN_W-1:0] TAG = WIN_W'(WIN_TAG);

  logic unused_addr;

  assign hit  = (addr[ADDR_W-1:WIN_LSB] == TAG);
  assign row  = addr[ROW_LSB +: ROW_W];
  assign bank = addr[BANK_LSB +: BANK_W];
  assign cmd  = addr[CMD_LSB +: 3];
  assign unused_addr = ^addr;
endmodule

// File: rtl/sdcmd_mode_ctrl.sv
module sdcmd_mode_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic wr,
  input  logic rd,
  output logic issue,
  output logic cke,
  output logic en
);
  assign issue = hit && wr && !en;

  always_ff @(posedge clk) begin
    if (rst) begin
      cke <= 1'b0;
      en  <= 1'b0;
    end else begin
      if (issue) cke <= 1'b1;
      if (hit && rd) en <= 1'b1;
    end
  end

  // R7
  en_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> en);
  // R6
  cke_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke);
endmodule

// File: rtl/sdcmd_pin_reg.sv
module sdcmd_pin_reg
  import sdcmd_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic [ROW_W-1:0]  row,
  input  logic [BANK_W-1:0] bank,
  input  sd_cmd_t           cmd,
  output logic              cs_n,
  output sd_cmd_t           rcw_n,
  output logic [ROW_W-1:0]  a,
  output logic [BANK_W-1:0] ba
);
  always_ff @(posedge clk) begin
    if (rst || !issue) begin
      cs_n  <= 1'b1;
      rcw_n <= CMD_NOP;
      a     <= '0;
      ba    <= '0;
    end else begin
      cs_n  <= 1'b0;
      rcw_n <= cmd;
      a     <= row;
      ba    <= bank;
    end
  end
endmodule

// File: rtl/sdcmd_port.sv
module sdcmd_port
  import sdcmd_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int ROW_W    = 13,
  parameter int BANK_W   = 2,
  parameter int BANK_LSB = 11,
  parameter int CMD_LSB  = 4,
  parameter int WIN_LSB  = 28,
  parameter int WIN_TAG  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ROW_W-1:0]  sd_a,
  output logic [BANK_W-1:0] sd_ba,
  output logic              ddr_en
);
  localparam int WIN_W = ADDR_W - WIN_LSB;

  logic              hit;
  logic              issue;
  logic [ROW_W-1:0]  row;
  logic [BANK_W-1:0] bank;
  sd_cmd_t           cmd;
  sd_cmd_t           rcw_n;

  sdcmd_field_decode #(
    .ADDR_W(ADDR_W), .ROW_W(ROW_W), .BANK_W(BANK_W), .BANK_LSB(BANK_LSB),
    .CMD_LSB(CMD_LSB), .WIN_LSB(WIN_LSB), .WIN_TAG(WIN_TAG)
  ) dec_i (
    .addr(bus_addr), .hit(hit), .row(row), .bank(bank), .cmd(cmd)
  );

  sdcmd_mode_ctrl mode_i (
    .clk(clk), .rst(rst), .hit(hit), .wr(bus_wr), .rd(bus_rd),
    .issue(issue), .cke(sd_cke), .en(ddr_en)
  );

  sdcmd_pin_reg #(.ROW_W(ROW_W), .BANK_W(BANK_W)) pins_i (
    .clk(clk), .rst(rst), .issue(issue), .row(row), .bank(bank), .cmd(cmd),
    .cs_n(sd_cs_n), .rcw_n(rcw_n), .a(sd_a), .ba(sd_ba)
  );

  assign {sd_ras_n, sd_cas_n, sd_we_n} = rcw_n;

  // R2
  one_cmd_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    !sd_cs_n |-> $past(bus_wr));
  // R2
  idle_nop_chk: assert property (@(posedge clk) disable iff (rst)
    sd_cs_n |-> ({sd_ras_n, sd_cas_n, sd_we_n} == CMD_NOP && sd_a == '0));
  // R9
  window_only_chk: assert property (@(posedge clk) disable iff (rst)
    !sd_cs_n |-> ($past(bus_addr[ADDR_W-1:WIN_LSB]) == WIN_W'(WIN_TAG)));
  // R8
  no_cmd_after_en_chk: assert property (@(posedge clk) disable iff (rst)
    ddr_en |=> sd_cs_n);
  // R6
  cke_with_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    !sd_cs_n |-> sd_cke);
endmodule

// File: tb/sdcmd_port_tb.sv
`timescale 1ns/1ps
module sdcmd_port_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] b_addr = '0;
  logic        b_wr = 1'b0;
  logic        b_rd = 1'b0;

  always #2 clk = ~clk;

  // instance outputs
  logic        o_cke[2], o_cs_n[2], o_en[2];
  logic [2:0]  o_cmd[2];
  logic [13:0] o_a[2];
  logic [1:0]  o_ba[2];
  logic [12:0] a0;
  logic [11:0] a1;
  logic        r0, c0, w0, r1, c1, w1;

  sdcmd_port dut_i (
    .clk(clk), .rst(rst), .bus_addr(b_addr), .bus_wr(b_wr), .bus_rd(b_rd),
    .sd_cke(o_cke[0]), .sd_cs_n(o_cs_n[0]), .sd_ras_n(r0), .sd_cas_n(c0),
    .sd_we_n(w0), .sd_a(a0), .sd_ba(o_ba[0]), .ddr_en(o_en[0])
  );

  sdcmd_port #(.ROW_W(12), .BANK_LSB(10)) dut_small_i (
    .clk(clk), .rst(rst), .bus_addr(b_addr), .bus_wr(b_wr), .bus_rd(b_rd),
    .sd_cke(o_cke[1]), .sd_cs_n(o_cs_n[1]), .sd_ras_n(r1), .sd_cas_n(c1),
    .sd_we_n(w1), .sd_a(a1), .sd_ba(o_ba[1]), .ddr_en(o_en[1])
  );

  assign o_cmd[0] = {r0, c0, w0};
  assign o_cmd[1] = {r1, c1, w1};
  assign o_a[0]   = {1'b0, a0};
  assign o_a[1]   = {2'b0, a1};

  // reference model
  int          row_w[2]    = '{13, 12};
  int          bank_pos[2] = '{11, 10};
  logic        m_cke[2], m_cs_n[2], m_en[2];
  logic [2:0]  m_cmd[2];
  logic [13:0] m_a[2];
  logic [1:0]  m_ba[2];

  always @(posedge clk) begin
    for (int c = 0; c < 2; c++) begin
      if (rst) begin
        m_cke[c] <= 0; m_en[c] <= 0; m_cs_n[c] <= 1;
        m_cmd[c] <= 3'd7; m_a[c] <= 0; m_ba[c] <= 0;
      end else begin
        if (b_addr[31:28] == 4'h1 && b_wr && !m_en[c]) begin
          m_cs_n[c] <= 0;
          m_cmd[c]  <= b_addr[6:4];
          m_a[c]    <= 14'((b_addr >> (bank_pos[c] + 2)) & ((32'd1 << row_w[c]) - 1));
          m_ba[c]   <= 2'((b_addr >> bank_pos[c]) & 32'd3);
          m_cke[c]  <= 1;
        end else begin
          m_cs_n[c] <= 1; m_cmd[c] <= 3'd7; m_a[c] <= 0; m_ba[c] <= 0;
        end
        if (b_addr[31:28] == 4'h1 && b_rd) m_en[c] <= 1;
      end
    end
  end

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 0;

  task automatic check(string req, int c, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s inst%0d t=%0t actual=%0h expected=%0h", req, c, $time, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    for (int c = 0; c < 2; c++) begin
      check("R2 cs_n", c, int'(o_cs_n[c]), int'(m_cs_n[c]));
      check("R3 ras/cas/we", c, int'(o_cmd[c]), int'(m_cmd[c]));
      check("R4 row lines", c, int'(o_a[c]), int'(m_a[c]));
      check("R5 bank lines", c, int'(o_ba[c]), int'(m_ba[c]));
      check("R6 cke", c, int'(o_cke[c]), int'(m_cke[c]));
      check("R7 enable", c, int'(o_en[c]), int'(m_en[c]));
    end
  end

  function automatic logic [31:0] mk(int row, int bank, int cmd);
    return 32'h1000_0000 | 32'(row << 13) | 32'(bank << 11) | 32'(cmd << 4);
  endfunction

  task automatic bus_wr(logic [31:0] a);
    @(negedge clk); b_addr = a; b_wr = 1;
    @(negedge clk); b_wr = 0;
  endtask

  task automatic bus_rd(logic [31:0] a);
    @(negedge clk); b_addr = a; b_rd = 1;
    @(negedge clk); b_rd = 0;
  endtask

  task automatic gap(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1 during reset
    check("R1 reset cke", 0, int'(o_cke[0]), 0);
    check("R1 reset cs_n", 0, int'(o_cs_n[0]), 1);
    check("R1 reset cmd", 0, int'(o_cmd[0]), 7);
    check("R1 reset en", 0, int'(o_en[0]), 0);
    rst = 0;
    @(negedge clk);
    check("R1 after reset cs_n", 1, int'(o_cs_n[1]), 1);

    // R9 outside window
    bus_wr(mk(16'h0400, 0, 2) ^ 32'h3000_0000);
    check("R9 outside write cs_n", 0, int'(o_cs_n[0]), 1);
    check("R9 outside write cke", 0, int'(o_cke[0]), 0);
    bus_rd(32'h0000_0000);
    gap(1);
    check("R9 outside read en", 0, int'(o_en[0]), 0);

    // bring-up sequence
    bus_wr(mk(0, 0, 7));
    check("R6 cke rises with first cmd", 0, int'(o_cke[0]), 1);
    gap(2);
    bus_wr(mk('h400, 0, 2)); gap(2);
    bus_wr(mk('h001, 1, 0)); gap(2);
    bus_wr(mk('h121, 0, 0)); gap(1);
    bus_wr(mk('h400, 0, 2));
    bus_wr(mk(0, 0, 1));
    bus_wr(mk(0, 0, 1));
    bus_wr(mk('h021, 0, 0));
    // back-to-back, full field values
    @(negedge clk); b_wr = 1; b_addr = mk('h1FFF, 3, 3);
    @(negedge clk); b_addr = mk('h0AAA, 2, 5);
    @(negedge clk); b_addr = mk('h1555, 1, 6);
    @(negedge clk); b_wr = 0;
    check("R3 last cmd code", 0, int'(o_cmd[0]), 6);
    gap(3);
    for (int i = 0; i < 16; i++) begin
      bus_wr(mk((i * 1237) & 'h1FFF, i & 3, i & 7));
    end
    gap(2);

    // R7 enable read, then R8 writes ignored
    check("R7 en before read", 0, int'(o_en[0]), 0);
    bus_rd(mk(0, 0, 0));
    check("R7 en after read", 0, int'(o_en[0]), 1);
    bus_wr(mk('h400, 0, 2));
    check("R8 write after enable cs_n", 0, int'(o_cs_n[0]), 1);
    check("R8 write after enable small cs_n", 1, int'(o_cs_n[1]), 1);
    bus_rd(mk(0, 0, 0));
    check("R6 cke holds after read", 0, int'(o_cke[0]), 1);
    gap(3);

    // R10 write and read together after a fresh reset
    @(negedge clk); rst = 1;
    gap(2);
    rst = 0;
    @(negedge clk); b_addr = mk('h0123, 2, 1); b_wr = 1; b_rd = 1;
    @(negedge clk); b_wr = 0; b_rd = 0;
    check("R10 cmd issued", 0, int'(o_cs_n[0]), 0);
    check("R10 en raised", 0, int'(o_en[0]), 1);
    check("R10 cke raised", 0, int'(o_cke[0]), 1);
    gap(3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule